// File: doc/BRIEF.md
# Descriptor-Driven Memory Transfer Engine

This block moves 16-bit data inside a single RAM under the control of descriptors held in that same RAM. A one-cycle request together with a descriptor address starts it. The engine reads the descriptor one 16-bit word at a time. The first word is a mode word, and its flags decide which optional fields follow, so the position of every later field depends on that word. The engine then carries out one of four kinds of operation: a copy from one memory location to another, a write of a constant held in the descriptor, a sum of two values written to a destination, or a batch of up to seven copies.

Each request performs one operation and writes the descriptor's counter back, one lower. When the counter reaches zero the descriptor can name a follow-on descriptor, which the engine runs in the same busy period. It can also name a 32-bit vector that goes out with a one-cycle interrupt. The RAM port is synchronous, and read data returns one cycle after the read is issued. All addresses are byte addresses of 16-bit words and are even.

Top module: `dma_desc_engine`

## Requirements
- R1: While reset is applied and after it is released, with no request, `busy_o`, `irq_o` and `mem_en_o` are low.
- R2: A request seen while idle raises `busy_o` on the next cycle. A request that arrives while busy is ignored: it writes to no memory location and changes no counter.
- R3: Descriptor layout, one 16-bit word per field at consecutive even addresses. The mode word sits at base and the counter at base+2. Then come the source (or constant), the operand address if the arithmetic flag is set, and the destination. Then the follow-on descriptor address, if chaining is set, as two words with the low half first. Then the interrupt vector, if the interrupt flag is set, as two words with the low half first. Mode bits: bit0 constant, bit1 arithmetic, bit2 chain, bit3 interrupt, bit4 batch, bits7:5 pair count, bit8 unit (1 = 16-bit word, 0 = byte).
- R4: Copy mode (no constant, arithmetic or batch flag) writes the word read at the source address to the destination address.
- R5: Constant mode writes the source field itself to the destination.
- R6: Arithmetic mode writes the sum, modulo the unit width, of the source value and the word at the operand address. The source value is the word at the source address, or the source field when the constant flag is also set.
- R7: In byte unit the value written is the low 8 bits of the result, zero-extended to 16 bits.
- R8: Batch mode reads pair count source/destination address pairs starting at base+4 and copies each one in turn. A count of 0 is treated as 1. The constant, arithmetic, chain and interrupt flags have no effect in this mode.
- R9: After each request the counter word at base+2 is rewritten as its old value minus one, modulo 2^16.
- R10: End actions happen only when the rewritten counter is zero. In that case, with chaining set, the low address bits of the follow-on address become the new base, and that descriptor is fetched and executed before `busy_o` falls.
- R11: With the interrupt flag set and the counter reaching zero, `irq_o` is high for exactly one cycle with `irq_vec_o` equal to the descriptor's vector. With chaining also set, the pulse comes after the follow-on address has been taken and before the follow-on descriptor runs.
- R12: `busy_o` falls after the final counter write or after the interrupt pulse. The RAM port is quiet while idle, and a write is always an enabled access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, one cycle |
| base_i | input | AW | Descriptor base address, taken with the request |
| busy_o | output | 1 | Engine is processing |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | AW | RAM byte address |
| mem_wdata_o | output | 16 | RAM write data |
| mem_rdata_i | input | 16 | RAM read data, valid one cycle after the read |
| irq_o | output | 1 | End-of-transfer interrupt pulse |
| irq_vec_o | output | 32 | Interrupt vector |

## Verification
The hardest case to reach is a chained descriptor that also raises the interrupt. The follow-on address has to be taken, the pulse issued, and the next descriptor fetched from a different layout, all within one busy period. The bench builds two linked descriptors with different flag sets and counts the pulses. It then checks both destinations and both counters. A request during a long seven-pair batch covers the ignored-request case, and random descriptors of varying layout run alongside the directed cases.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CAP, S_WR, S_WC, S_IRQ
  } state_t;

  typedef enum logic [3:0] {
    F_MOD, F_CNT, F_SRC, F_OPR, F_DST,
    F_CHL, F_CHH, F_IVL, F_IVH, F_DAT, F_OPD
  } fld_t;

  typedef struct packed {
    logic       imm;
    logic       arith;
    logic       chain;
    logic       irq;
    logic       multi;
    logic [2:0] npairs;
    logic       word;
  } mode_t;
endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
  import dma_desc_pkg::*;
(
  input  logic [WORD_W-1:0] mode_word,
  output mode_t             mode
);
  logic multi;
  assign multi = mode_word[4];

  always_comb begin
    mode.multi  = multi;
    mode.imm    = mode_word[0] & ~multi;
    mode.arith  = mode_word[1] & ~multi;
    mode.chain  = mode_word[2] & ~multi;
    mode.irq    = mode_word[3] & ~multi;
    mode.npairs = (mode_word[7:5] == 3'd0) ? 3'd1 : mode_word[7:5];
    mode.word   = mode_word[8];
  end
endmodule

// File: rtl/dma_unit_alu.sv
module dma_unit_alu #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          add,
  input  logic          word,
  output logic [DW-1:0] y
);
  logic [DW-1:0] raw;
  assign raw = add ? (a + b) : a;
  assign y   = word ? raw : {{(DW-BW){1'b0}}, raw[BW-1:0]};
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_desc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [AW-1:0]     base_i,
  output logic              busy_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              irq_o,
  output logic [31:0]       irq_vec_o
);
  localparam logic [AW-1:0] STEP = AW'(2);

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s_n = rs2_q;

  state_t state_q, state_d;
  fld_t   fld_q, fld_d;
  logic [AW-1:0]     base_q, ptr_q;
  logic [WORD_W-1:0] mode_q, cnt_q, src_q, opr_q, dst_q, acc_q;
  logic [31:0]       chain_q, vec_q;
  logic [2:0]        pidx_q;
  mode_t             md;
  logic [WORD_W-1:0] cnt_dec, alu_y;
  logic              start_data, alu_add, desc_fld, end_hit;

  dma_mode_decode u_dec (.mode_word(mode_q), .mode(md));

  dma_unit_alu #(.DW(WORD_W), .BW(8)) u_alu (
    .a(acc_q), .b(mem_rdata_i), .add(alu_add), .word(md.word), .y(alu_y)
  );

  assign cnt_dec  = cnt_q - 1'b1;
  assign end_hit  = (cnt_dec == '0) && (md.chain || md.irq);
  assign alu_add  = (state_q == S_CAP) && (fld_q == F_OPD);
  assign desc_fld = (fld_q != F_DAT) && (fld_q != F_OPD);

  // next-state
  always_comb begin
    state_d    = state_q;
    fld_d      = fld_q;
    start_data = 1'b0;
    case (state_q)
      S_IDLE: if (req_i) begin state_d = S_RD; fld_d = F_MOD; end
      S_RD:   state_d = S_CAP;
      S_CAP: begin
        state_d = S_RD;
        case (fld_q)
          F_MOD: fld_d = F_CNT;
          F_CNT: fld_d = F_SRC;
          F_SRC: fld_d = md.arith ? F_OPR : F_DST;
          F_OPR: fld_d = F_DST;
          F_DST: begin
            if (md.multi)      fld_d = F_DAT;
            else if (md.chain) fld_d = F_CHL;
            else if (md.irq)   fld_d = F_IVL;
            else               start_data = 1'b1;
          end
          F_CHL: fld_d = F_CHH;
          F_CHH: if (md.irq) fld_d = F_IVL; else start_data = 1'b1;
          F_IVL: fld_d = F_IVH;
          F_IVH: start_data = 1'b1;
          F_DAT: if (md.arith) fld_d = F_OPD; else state_d = S_WR;
          default: state_d = S_WR;
        endcase
        if (start_data) begin
          if (!md.imm)       fld_d = F_DAT;
          else if (md.arith) fld_d = F_OPD;
          else               state_d = S_WR;
        end
      end
      S_WR: begin
        if (md.multi && (pidx_q < md.npairs)) begin
          state_d = S_RD;
          fld_d   = F_SRC;
        end else begin
          state_d = S_WC;
        end
      end
      S_WC: begin
        fld_d = F_MOD;
        if (!end_hit)    state_d = S_IDLE;
        else if (md.irq) state_d = S_IRQ;
        else             state_d = S_RD;
      end
      default: begin
        fld_d   = F_MOD;
        state_d = md.chain ? S_RD : S_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= S_IDLE;
      fld_q   <= F_MOD;
      base_q  <= '0;
      ptr_q   <= '0;
      mode_q  <= '0;
      cnt_q   <= '0;
      src_q   <= '0;
      opr_q   <= '0;
      dst_q   <= '0;
      acc_q   <= '0;
      chain_q <= '0;
      vec_q   <= '0;
      pidx_q  <= 3'd1;
    end else begin
      state_q <= state_d;
      fld_q   <= fld_d;
      if (state_q == S_IDLE && req_i) begin
        base_q <= base_i;
        ptr_q  <= base_i;
        pidx_q <= 3'd1;
      end
      if (state_q == S_CAP) begin
        if (desc_fld) ptr_q <= ptr_q + STEP;
        case (fld_q)
          F_MOD: mode_q         <= mem_rdata_i;
          F_CNT: cnt_q          <= mem_rdata_i;
          F_SRC: src_q          <= mem_rdata_i;
          F_OPR: opr_q          <= mem_rdata_i;
          F_DST: dst_q          <= mem_rdata_i;
          F_CHL: chain_q[15:0]  <= mem_rdata_i;
          F_CHH: chain_q[31:16] <= mem_rdata_i;
          F_IVL: vec_q[15:0]    <= mem_rdata_i;
          F_IVH: vec_q[31:16]   <= mem_rdata_i;
          F_DAT: acc_q          <= mem_rdata_i;
          default: acc_q        <= alu_y;
        endcase
        if (start_data && md.imm) acc_q <= src_q;
      end
      if (state_q == S_WR) pidx_q <= pidx_q + 3'd1;
      if (state_q == S_WC) begin
        pidx_q <= 3'd1;
        if (end_hit && md.chain) begin
          base_q <= chain_q[AW-1:0];
          ptr_q  <= chain_q[AW-1:0];
        end
      end
    end
  end

  // outputs
  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_q;
    mem_wdata_o = alu_y;
    case (state_q)
      S_RD: begin
        mem_en_o = 1'b1;
        if (fld_q == F_DAT)      mem_addr_o = src_q[AW-1:0];
        else if (fld_q == F_OPD) mem_addr_o = opr_q[AW-1:0];
      end
      S_WR: begin
        mem_en_o   = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = dst_q[AW-1:0];
      end
      S_WC: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = base_q + STEP;
        mem_wdata_o = cnt_dec;
      end
      default: ;
    endcase
  end

  assign busy_o    = (state_q != S_IDLE);
  assign irq_o     = (state_q == S_IRQ);
  assign irq_vec_o = vec_q;
endmodule

// File: rtl/dma_desc_engine_chk.sv
module dma_desc_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic busy_o,
  input logic mem_en_o,
  input logic mem_we_o,
  input logic irq_o
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i) |=> busy_o);
  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R11
  irq_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> busy_o);
  // R12
  we_has_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_en_o);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_en_o);
  // R1
  idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !irq_o);
endmodule

bind dma_desc_engine dma_desc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .req_i(req_i), .busy_o(busy_o),
  .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .irq_o(irq_o)
);

// File: tb/dma_desc_engine_tb.sv
module dma_desc_engine_tb;
  localparam int AW = 16;
  localparam int SEED = 1234;

  logic clk, rst_n, req_i, busy_o, mem_en_o, mem_we_o, irq_o;
  logic [AW-1:0] base_i, mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i;
  logic [31:0] irq_vec_o;

  logic [15:0] ram [0:32767];
  int errors = 0, checks = 0, irq_cnt = 0;
  logic [31:0] vec_last;
  bit done = 0;

  dma_desc_engine #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .base_i(base_i),
    .busy_o(busy_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .irq_o(irq_o), .irq_vec_o(irq_vec_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_en_o && mem_we_o) ram[mem_addr_o[15:1]] <= mem_wdata_o;
    else if (mem_en_o) mem_rdata_i <= ram[mem_addr_o[15:1]];
    if (irq_o) begin
      irq_cnt <= irq_cnt + 1;
      vec_last <= irq_vec_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [15:0] a);
    return ram[a[15:1]];
  endfunction

  task automatic wr(input logic [15:0] a, input logic [15:0] v);
    ram[a[15:1]] = v;
  endtask

  // R3 layout writer
  task automatic build(input logic [15:0] b, input logic [15:0] m, input logic [15:0] c,
                       input logic [15:0] s, input logic [15:0] o, input logic [15:0] d,
                       input logic [31:0] ch, input logic [31:0] v);
    logic [15:0] p;
    p = b;
    wr(p, m); p += 2;
    wr(p, c); p += 2;
    wr(p, s); p += 2;
    if (m[1]) begin wr(p, o); p += 2; end
    wr(p, d); p += 2;
    if (m[2]) begin wr(p, ch[15:0]); p += 2; wr(p, ch[31:16]); p += 2; end
    if (m[3]) begin wr(p, v[15:0]); p += 2; wr(p, v[31:16]); end
  endtask

  function automatic logic [15:0] expv(input logic [15:0] m, input logic [15:0] sf,
                                       input logic [15:0] sm, input logic [15:0] om);
    logic [15:0] a;
    a = m[0] ? sf : sm;
    if (m[1]) a = a + om;
    if (!m[8]) a = {8'h00, a[7:0]};
    return a;
  endfunction

  task automatic start(input logic [15:0] b);
    @(negedge clk);
    req_i = 1; base_i = b;
    @(negedge clk);
    req_i = 0;
  endtask

  task automatic run(input logic [15:0] b);
    int n;
    start(b);
    chk(busy_o === 1'b1, "R2", {31'b0, busy_o}, 1);
    n = 0;
    while (busy_o && n < 3000) begin @(negedge clk); n++; end
    chk(!busy_o, "R12", {31'b0, busy_o}, 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int i0;
    logic [15:0] m, c, s, o, d, sm, om, b;
    void'($urandom(SEED));
    req_i = 0; base_i = '0; rst_n = 0;
    for (int k = 0; k < 32768; k++) ram[k] = 16'h0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !irq_o && !mem_en_o, "R1", {busy_o, irq_o, mem_en_o}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!busy_o && !irq_o && !mem_en_o, "R1", {busy_o, irq_o, mem_en_o}, 0);

    // R4 word copy
    wr(16'h2000, 16'hBEEF);
    build(16'h0100, 16'h0100, 16'd3, 16'h2000, 0, 16'h2100, 0, 0);
    run(16'h0100);
    chk(rd(16'h2100) == 16'hBEEF, "R4", rd(16'h2100), 16'hBEEF);
    chk(rd(16'h0102) == 16'd2, "R9", rd(16'h0102), 2);
    chk(irq_cnt == 0, "R10", irq_cnt, 0);

    // R7 byte copy
    build(16'h0100, 16'h0000, 16'd5, 16'h2000, 0, 16'h2102, 0, 0);
    run(16'h0100);
    chk(rd(16'h2102) == 16'h00EF, "R7", rd(16'h2102), 16'h00EF);

    // R5 constant
    build(16'h0100, 16'h0101, 16'd5, 16'h1234, 0, 16'h2104, 0, 0);
    run(16'h0100);
    chk(rd(16'h2104) == 16'h1234, "R5", rd(16'h2104), 16'h1234);

    // R6 arithmetic word with wrap
    wr(16'h2010, 16'hFFF0); wr(16'h2012, 16'h0020);
    build(16'h0100, 16'h0102, 16'd5, 16'h2010, 16'h2012, 16'h2106, 0, 0);
    run(16'h0100);
    chk(rd(16'h2106) == 16'h0010, "R6", rd(16'h2106), 16'h0010);
    // R6 R7 byte arithmetic
    wr(16'h2014, 16'h12F0);
    build(16'h0100, 16'h0002, 16'd5, 16'h2014, 16'h2012, 16'h2108, 0, 0);
    run(16'h0100);
    chk(rd(16'h2108) == 16'h0010, "R6", rd(16'h2108), 16'h0010);

    // R8 batch of 3, constant flag ignored
    for (int k = 0; k < 3; k++) begin
      wr(16'h2200 + 2*k, 16'hA000 + k);
      wr(16'h0204 + 4*k, 16'h2200 + 2*k);
      wr(16'h0206 + 4*k, 16'h2300 + 2*k);
    end
    wr(16'h0200, 16'h0100 | 16'h0010 | (3 << 5) | 16'h0001);
    wr(16'h0202, 16'd9);
    run(16'h0200);
    for (int k = 0; k < 3; k++)
      chk(rd(16'h2300 + 2*k) == 16'hA000 + k, "R8", rd(16'h2300 + 2*k), 16'hA000 + k);
    chk(rd(16'h0202) == 16'd8, "R9", rd(16'h0202), 8);

    // R10 R11 interrupt only at zero
    build(16'h0300, 16'h0108, 16'd2, 16'h2000, 0, 16'h2400, 0, 32'hCAFE_0123);
    run(16'h0300);
    chk(irq_cnt == 0, "R10", irq_cnt, 0);
    run(16'h0300);
    chk(irq_cnt == 1, "R11", irq_cnt, 1);
    chk(vec_last == 32'hCAFE_0123, "R11", vec_last, 32'hCAFE_0123);
    chk(rd(16'h0302) == 16'd0, "R9", rd(16'h0302), 0);

    // R9 wrap from zero
    build(16'h0300, 16'h0100, 16'd0, 16'h2000, 0, 16'h2402, 0, 0);
    run(16'h0300);
    chk(rd(16'h0302) == 16'hFFFF, "R9", rd(16'h0302), 16'hFFFF);

    // R10 chain to a constant descriptor
    build(16'h0500, 16'h0101, 16'd4, 16'h5555, 0, 16'h2502, 0, 0);
    build(16'h0400, 16'h0104, 16'd1, 16'h2000, 0, 16'h2500, 32'h0001_0500, 0);
    run(16'h0400);
    chk(rd(16'h2500) == 16'hBEEF, "R10", rd(16'h2500), 16'hBEEF);
    chk(rd(16'h2502) == 16'h5555, "R10", rd(16'h2502), 16'h5555);
    chk(rd(16'h0502) == 16'd3, "R10", rd(16'h0502), 3);

    // R11 chain plus interrupt, follow-on arithmetic
    wr(16'h2020, 16'h0003); wr(16'h2022, 16'h0004);
    build(16'h0700, 16'h0102, 16'd2, 16'h2020, 16'h2022, 16'h2602, 0, 0);
    build(16'h0600, 16'h010C, 16'd1, 16'h2000, 0, 16'h2600, 32'h0000_0700, 32'h1357_9BDF);
    i0 = irq_cnt;
    run(16'h0600);
    chk(irq_cnt == i0 + 1, "R11", irq_cnt, i0 + 1);
    chk(vec_last == 32'h1357_9BDF, "R11", vec_last, 32'h1357_9BDF);
    chk(rd(16'h2602) == 16'h0007, "R11", rd(16'h2602), 7);
    chk(rd(16'h0702) == 16'd1, "R11", rd(16'h0702), 1);

    // R2 request while busy on a seven-pair batch is ignored; R3 last pair at base+30
    for (int k = 0; k < 7; k++) begin
      wr(16'h2800 + 2*k, 16'hB000 + k);
      wr(16'h0804 + 4*k, 16'h2800 + 2*k);
      wr(16'h0806 + 4*k, 16'h2900 + 2*k);
    end
    wr(16'h0800, 16'h0100 | 16'h0010 | (7 << 5));
    wr(16'h0802, 16'd1);
    build(16'h0A00, 16'h0101, 16'd7, 16'h7777, 0, 16'h2A00, 0, 0);
    start(16'h0800);
    repeat (4) @(negedge clk);
    req_i = 1; base_i = 16'h0A00;
    @(negedge clk); req_i = 0;
    for (int n = 0; n < 3000 && busy_o; n++) @(negedge clk);
    chk(rd(16'h2A00) == 16'h0, "R2", rd(16'h2A00), 0);
    chk(rd(16'h0A02) == 16'd7, "R2", rd(16'h0A02), 7);
    chk(rd(16'h290C) == 16'hB006, "R3", rd(16'h290C), 16'hB006);
    chk(rd(16'h0802) == 16'd0, "R8", rd(16'h0802), 0);

    // random single transfers
    for (int t = 0; t < 40; t++) begin
      m = {7'b0, 1'($urandom), 6'b0, 2'($urandom)};
      c = 16'($urandom_range(2, 500));
      sm = 16'($urandom); om = 16'($urandom);
      s = m[0] ? 16'($urandom) : 16'h3000 + 16'(4*t);
      o = 16'h3200 + 16'(4*t);
      d = 16'h3400 + 16'(2*t);
      b = 16'h1000 + 16'(32*t);
      if (!m[0]) wr(s, sm);
      wr(o, om);
      build(b, m, c, s, o, d, 0, 0);
      run(b);
      chk(rd(d) == expv(m, s, sm, om), "R6", rd(d), expv(m, s, sm, om));
      chk(rd(b + 2) == c - 1, "R9", rd(b + 2), c - 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule